// File: doc/BRIEF.md
# Level-Triggered DMA Request Acceptance Controller

This block is the front end of one DMA channel. It watches an active-low request line from a peripheral and decides when that request is accepted. It then asks for the bus and runs one single-address transfer cycle for each accepted request. The controller only decides when requests are taken and when a bus cycle starts. Addresses, data movement and arbitration between channels belong to other blocks. The bus cycle itself is modelled as a fixed number of clock cycles during which an acknowledge is held high.

Software loads a transfer count and then writes the channel enable bit to 1. From the first clock edge after that write, the request line is sampled on every edge while acceptance is open. A low level latches a pending request, and the controller raises its bus request. When grant arrives, the channel activates: the pending request is cleared and the transfer cycle runs. Request sampling stays closed from activation until the cycle has finished. An optional delay bit keeps it closed for one more cycle after each transfer. When the count runs out, the controller drops enable by itself and reports completion.

Top module: `dma_req_top`

## Requirements
- R1: After reset, busy, done, busReq, xferAck and xferStrobe are all 0, and the request line is not sampled.
- R2: A write with enWrite=1 and enData=1 while idle, with a nonzero loaded count, makes busy 1 from the next cycle. The request line is not sampled at the edge that ends the write cycle. The first sample is taken at the edge after it.
- R3: While acceptance is open, dreqN=0 at a rising edge latches a pending request, and busReq is 1 from the next cycle. busReq stays 1, with xferAck 0, for as long as busGrant is 0.
- R4: busGrant=1 at an edge while a request is pending clears the pending request (busReq falls) and activates the channel. xferAck is then 1 for exactly XFER_LEN cycles (XFER_LEN >= 3, default 3), and xferStrobe is 1 only in the first of those cycles.
- R5: From activation until acceptance reopens, dreqN is ignored. A low level held only during the transfer cycle produces no new request.
- R6: With nrdEn=0 in the last transfer cycle, acceptance reopens in the first cycle after xferAck falls. A low dreqN at the edge that ends that cycle raises busReq in the following cycle.
- R7: With nrdEn=1 in the last transfer cycle, acceptance reopens one cycle later than in R6. busReq therefore cannot rise before the second cycle after xferAck falls.
- R8: Each completed transfer lowers the count by one. After the transfer that uses up the count, busy is 0 and done is 1, and no further request is accepted.
- R9: A write with enWrite=1 and enData=0 in any state makes busy 0 and busReq 0 from the next cycle. Any pending request is discarded, so it gives no busReq after a later re-enable while dreqN is high.
- R10: cntLoad is ignored while busy, and the remaining number of transfers is unchanged. An enable write while the count is 0 leaves the controller idle.
- R11: done stays 1 until, while idle, either cntLoad=1 or an enable write with enData=1 occurs. Either one clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| enWrite | input | 1 | Strobe for a write to the channel enable bit |
| enData | input | 1 | Value written to the enable bit when enWrite is 1 |
| nrdEn | input | 1 | 1 adds one extra closed cycle after each transfer |
| dreqN | input | 1 | Active-low peripheral request, level sensed |
| busGrant | input | 1 | Bus grant for this channel |
| cntLoad | input | 1 | Loads cntValue into the transfer counter while idle |
| cntValue | input | CNT_W | Number of transfers to perform |
| busReq | output | 1 | Bus request, high while a request is pending |
| xferAck | output | 1 | Acknowledge to the peripheral for the whole transfer cycle |
| xferStrobe | output | 1 | One-cycle pulse at the start of each transfer cycle |
| busy | output | 1 | Channel enabled |
| done | output | 1 | Transfer count used up |

## Verification
On every clock, the embedded assertions check the following. busReq and xferAck are never high together. An acknowledge only starts after a granted request. An acknowledge lasts past its first cycle. The counter never decrements from zero. done never coexists with busy. A disable write always ends busy on the next cycle. The exact placement of the closed window is shown only by the bench's scenarios, which compare against a cycle model. These scenarios cover the edge that is skipped after the enable write, the one-cycle stretch under nrdEn, request pulses that fall inside the window, and the loss of a pending request on abort. The same applies to the ignored count load and the enable with a zero count.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_PEND,
    ST_XFER,
    ST_GAP
  } ctlState_t;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic beatStart;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_req_dp.sv
module dma_req_dp
  import dma_req_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int XFER_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntValue,
  output logic             cntZero,
  output logic             cntOne,
  output logic             beatFirst,
  output logic             beatLast
);

  localparam int BEAT_W = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1;
  localparam logic [BEAT_W-1:0] BEAT_TOP = BEAT_W'(XFER_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntLoad) begin
      cnt <= cntValue;
    end else if (strobe.cntDec) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat <= '0;
    end else if (strobe.beatStart) begin
      beat <= BEAT_TOP;
    end else if (beat != '0) begin
      beat <= beat - 1'b1;
    end
  end

  assign cntZero   = (cnt == '0);
  assign cntOne    = (cnt == CNT_W'(1));
  assign beatFirst = (beat == BEAT_TOP);
  assign beatLast  = (beat == '0);

  // R8: the counter is only decremented while transfers remain
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |-> (cnt != '0));

  // R4: a started beat opens at its first position
  assert_beat_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatStart |=> beatFirst);

endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl
  import dma_req_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWrite,
  input  logic       enData,
  input  logic       nrdEn,
  input  logic       dreqN,
  input  logic       busGrant,
  input  logic       cntLoadIn,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       beatFirst,
  input  logic       beatLast,
  output ctlStrobe_t strobe,
  output logic       busReq,
  output logic       xferAck,
  output logic       xferStrobe,
  output logic       busy,
  output logic       done
);

  ctlState_t state, stateNxt;
  logic enOn, enOff, lastBeat, finish, doneNxt;

  assign enOn     = enWrite && enData;
  assign enOff    = enWrite && !enData;
  assign lastBeat = (state == ST_XFER) && beatLast;
  assign finish   = lastBeat && cntOne && !enOff;

  always_comb begin
    stateNxt = state;
    if (enOff) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   if (enOn && !cntZero) stateNxt = ST_ACCEPT;
        ST_ACCEPT: if (!dreqN)           stateNxt = ST_PEND;
        ST_PEND:   if (busGrant)         stateNxt = ST_XFER;
        ST_XFER: begin
          if (beatLast) begin
            if (cntOne)     stateNxt = ST_IDLE;
            else if (nrdEn) stateNxt = ST_GAP;
            else            stateNxt = ST_ACCEPT;
          end
        end
        ST_GAP:    stateNxt = ST_ACCEPT;
        default:   stateNxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    doneNxt = done;
    if (finish) doneNxt = 1'b1;
    else if ((state == ST_IDLE) && (enOn || cntLoadIn)) doneNxt = 1'b0;
  end

  always_comb begin
    strobe.cntLoad   = cntLoadIn && (state == ST_IDLE);
    strobe.cntDec    = lastBeat && !enOff;
    strobe.beatStart = (state == ST_PEND) && busGrant && !enOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign busReq     = (state == ST_PEND);
  assign xferAck    = (state == ST_XFER);
  assign xferStrobe = (state == ST_XFER) && beatFirst;
  assign busy       = (state != ST_IDLE);

  // R3: request and acknowledge never overlap
  assert_req_ack_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && xferAck));

  // R4: an acknowledge only begins after a granted request
  assert_ack_after_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferAck) |-> ($past(busGrant) && $past(busReq)));

  // R5: the closed window spans more than the activation cycle
  assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferAck) && !enOff) |=> xferAck);

  // R7: the delay bit inserts one idle cycle before acceptance
  assert_gap_after_xfer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferAck && beatLast && nrdEn && !cntOne && !enOff) |=> (!xferAck && !busReq && busy) ##1 !busReq);

  // R8: completion and activity are exclusive
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: a disable write always ends activity
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    enOff |=> (!busy && !busReq));

endmodule

// File: rtl/dma_req_top.sv
module dma_req_top
  import dma_req_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int XFER_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWrite,
  input  logic             enData,
  input  logic             nrdEn,
  input  logic             dreqN,
  input  logic             busGrant,
  input  logic             cntLoad,
  input  logic [CNT_W-1:0] cntValue,
  output logic             busReq,
  output logic             xferAck,
  output logic             xferStrobe,
  output logic             busy,
  output logic             done
);

  generate
    if (XFER_LEN < 3) begin : g_len_check
      $error("XFER_LEN must be at least 3");
    end
  endgenerate

  ctlStrobe_t strobe;
  logic cntZero, cntOne, beatFirst, beatLast;

  dma_req_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enWrite    (enWrite),
    .enData     (enData),
    .nrdEn      (nrdEn),
    .dreqN      (dreqN),
    .busGrant   (busGrant),
    .cntLoadIn  (cntLoad),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .beatFirst  (beatFirst),
    .beatLast   (beatLast),
    .strobe     (strobe),
    .busReq     (busReq),
    .xferAck    (xferAck),
    .xferStrobe (xferStrobe),
    .busy       (busy),
    .done       (done)
  );

  dma_req_dp #(.CNT_W(CNT_W), .XFER_LEN(XFER_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntValue  (cntValue),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .beatFirst (beatFirst),
    .beatLast  (beatLast)
  );

endmodule

// File: tb/tb_dma_req_top.sv
module tb_dma_req_top;

  localparam int CNT_W    = 8;
  localparam int XFER_LEN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enWrite = 1'b0, enData = 1'b0, nrdEn = 1'b0, dreqN = 1'b1;
  logic busGrant = 1'b0, cntLoad = 1'b0;
  logic [CNT_W-1:0] cntValue = '0;
  logic busReq, xferAck, xferStrobe, busy, done;

  int nTests = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  dma_req_top #(.CNT_W(CNT_W), .XFER_LEN(XFER_LEN)) dut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enData(enData),
    .nrdEn(nrdEn), .dreqN(dreqN), .busGrant(busGrant), .cntLoad(cntLoad),
    .cntValue(cntValue), .busReq(busReq), .xferAck(xferAck),
    .xferStrobe(xferStrobe), .busy(busy), .done(done)
  );

  // Behavioural reference: phase 0 idle, 1 open, 2 waiting grant, 3 moving, 4 extra closed cycle
  int mPhase = 0;
  int mLeft = 0;
  int mTicks = 0;
  bit mDone = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase <= 0; mLeft <= 0; mTicks <= 0; mDone <= 1'b0;
    end else begin
      if (mPhase == 0 && cntLoad) mLeft <= int'(cntValue);
      if (mPhase == 0 && (cntLoad || (enWrite && enData))) mDone <= 1'b0;
      if (enWrite && !enData) begin
        mPhase <= 0;
      end else if (mPhase == 0) begin
        if (enWrite && enData && mLeft > 0) mPhase <= 1;
      end else if (mPhase == 1) begin
        if (!dreqN) mPhase <= 2;
      end else if (mPhase == 2) begin
        if (busGrant) begin mPhase <= 3; mTicks <= 1; end
      end else if (mPhase == 3) begin
        if (mTicks == XFER_LEN) begin
          mLeft <= mLeft - 1;
          if (mLeft == 1) begin mPhase <= 0; mDone <= 1'b1; end
          else mPhase <= nrdEn ? 4 : 1;
        end else begin
          mTicks <= mTicks + 1;
        end
      end else begin
        mPhase <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic [4:0] act = {busReq, xferAck, xferStrobe, busy, done};
      automatic logic [4:0] exp = {mPhase == 2, mPhase == 3,
                                   mPhase == 3 && mTicks == 1, mPhase != 0, mDone};
      nTests++;
      if (act !== exp) begin
        nFails++;
        $display("FAIL model R3 R4 R8 outputs act=%b exp=%b at %0t", act, exp, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enableCh(input bit v);
    enWrite = 1'b1; enData = v;
    step();
    enWrite = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog hung run act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    step(2);
    // R1 reset state
    chk(!busy && !done && !busReq && !xferAck && !xferStrobe, "R1 reset outputs", busy, 0);
    rstN = 1'b1;
    step();

    // Scenario A: count 2, no delay, request held low, grant high
    cntValue = 2; cntLoad = 1'b1; step(); cntLoad = 1'b0;
    nrdEn = 1'b0; dreqN = 1'b0; busGrant = 1'b1;
    enableCh(1'b1);
    chk(busy && !busReq, "R2 no sample at write edge", busReq, 0);
    step(); chk(busReq == 1'b1, "R3 request latched", busReq, 1);
    step(); chk(xferAck && xferStrobe && !busReq, "R4 activation", xferAck, 1);
    step(); chk(xferAck && !xferStrobe && !busReq, "R5 low level ignored during transfer", busReq, 0);
    step(); chk(xferAck && !busReq, "R4 ack length", xferAck, 1);
    step(); chk(!xferAck && !busReq, "R6 ack ended", xferAck, 0);
    step(); chk(busReq == 1'b1, "R6 reopen without delay", busReq, 1);
    step(4); chk(!busy && done, "R8 count used up", busy, 0);
    step(); chk(!busReq && !busy, "R8 no request after done", busReq, 0);

    // Scenario B: delay bit set
    cntValue = 2; cntLoad = 1'b1; step(); cntLoad = 1'b0;
    chk(done == 1'b0, "R11 done cleared by load", done, 0);
    nrdEn = 1'b1;
    enableCh(1'b1);
    step(2); chk(xferAck == 1'b1, "R4 second scenario ack", xferAck, 1);
    step(3); chk(!xferAck && !busReq, "R7 ack ended", xferAck, 0);
    step(); chk(!busReq && busy, "R7 extra closed cycle", busReq, 0);
    step(); chk(busReq == 1'b1, "R7 reopen after delay", busReq, 1);
    for (int i = 0; i < 20 && busy; i++) step();
    chk(done == 1'b1, "R8 done with delay", done, 1);

    // Scenario C: grant withheld, then abort
    nrdEn = 1'b0; busGrant = 1'b0;
    cntValue = 3; cntLoad = 1'b1; step(); cntLoad = 1'b0;
    enableCh(1'b1);
    step(); chk(busReq == 1'b1, "R3 request raised", busReq, 1);
    step(3); chk(busReq && !xferAck, "R3 held without grant", busReq, 1);
    enableCh(1'b0);
    chk(!busy && !busReq, "R9 abort", busy, 0);
    dreqN = 1'b1; busGrant = 1'b1;
    enableCh(1'b1);
    step(2); chk(!busReq && busy, "R9 pending request discarded", busReq, 0);

    // Scenario E: low level only inside the closed window
    dreqN = 1'b0; step(); dreqN = 1'b1;
    chk(busReq == 1'b1, "R3 pulse accepted", busReq, 1);
    step(); chk(xferAck == 1'b1, "R4 pulse activation", xferAck, 1);
    dreqN = 1'b0; step(2); dreqN = 1'b1;
    step(); chk(!xferAck, "R5 ack ended", xferAck, 0);
    step(2); chk(!busReq && busy, "R5 window pulse ignored", busReq, 0);

    // Scenario F: load while busy is ignored (2 transfers remain)
    cntValue = 9; cntLoad = 1'b1; step(); cntLoad = 1'b0;
    dreqN = 1'b0;
    begin
      automatic int strobes = 0;
      for (int i = 0; i < 100 && busy; i++) begin
        if (xferStrobe) strobes++;
        step();
      end
      chk(strobes == 2, "R10 load ignored while busy", strobes, 2);
    end
    chk(done == 1'b1, "R8 done after remaining", done, 1);
    enableCh(1'b1);
    step();
    chk(!busy, "R10 enable with zero count", busy, 0);
    chk(!done, "R11 done cleared by enable write", done, 0);

    step(2);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule